// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Controller

This block sits at the decode point of a processor front end that feeds two parallel integer pipelines: a primary lane and a secondary lane. Up to two instructions arrive per cycle as compact descriptors. They pass through a prefetch register and a decode register. At decode the block decides whether both may leave together, one in each lane, or whether only the older one leaves. After issue, each lane carries its instruction through address generation, execute and writeback. The block reports which of the five stages each lane has occupied.

Pairing is refused in four cases: the two instructions depend on each other, either one carries a displacement or an immediate, either one is complex, or a floating-point instruction meets an integer one. On a refusal the older instruction goes to the primary lane. The younger one stays in decode and goes to the primary lane alone in the following cycle. A hazard stall raised by either lane freezes both lanes and the front registers in the same cycle.

Top module: `dual_issue_pair_ctl`

## Requirements
- R1: During and right after reset, every stage of both lanes is empty, `issue_pair`, `issue_single` and `lane_stall` are 0, and `in_ready` is 1.
- R2: A descriptor (default widths) holds its tag in [3:0], destination in [6:4], first source in [9:7], second source in [12:10], and the flags write-enable [13], floating-point [14], complex [15], displacement [16] and immediate [17]. Two instructions in decode that break no pairing rule issue together, the older (slot 0) to the primary lane and the younger to the secondary lane. `issue_pair` and `issue_single` are never both high.
- R3: Pairing is refused when the older instruction writes a register that the younger one reads as either source.
- R4: Pairing is refused when both instructions write the same destination register.
- R5: Pairing is refused when either instruction has its displacement flag or its immediate flag set.
- R6: Pairing is refused when either instruction is complex, so a complex instruction always issues alone in the primary lane.
- R7: Pairing is refused when exactly one of the two instructions is floating-point. Two floating-point instructions pair, as two integer ones do.
- R8: On a refusal, `issue_single` rises with the older tag on `issue_tag_p`. In the next unstalled cycle the younger one issues alone in the primary lane. Decode takes nothing new until it is empty, and `in_ready` is low while a full prefetch register cannot move on.
- R9: An accepted input enters prefetch at the next edge and moves to decode at the edge after that, if decode is free. An issued instruction is in address generation one cycle after issue, in execute after two cycles and in writeback after three. `wb_tag_p` and `wb_tag_s` carry the tag held in writeback. Occupancy bit order is prefetch [0], decode [1], address generation [2], execute [3], writeback [4].
- R10: Any bit set in `stall_req` sets both bits of `lane_stall` in the same cycle. While any bit is set, no issue happens, `in_ready` is 0 and no stage of either lane changes.
- R11: An input with only slot 1 valid (`in_vld` = 2'b10) is placed in the primary slot of prefetch, so it issues in the primary lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 2 | Valid bit per input slot (bit 0 older) |
| in_a | input | 18 | Older instruction descriptor |
| in_b | input | 18 | Younger instruction descriptor |
| in_ready | output | 1 | Input is taken this cycle |
| stall_req | input | 2 | Hazard stall request per lane |
| lane_stall | output | 2 | Stall applied to each lane |
| issue_pair | output | 1 | Both decode instructions issue this cycle |
| issue_single | output | 1 | Only the primary lane issues this cycle |
| issue_tag_p | output | 4 | Tag issued to the primary lane |
| issue_tag_s | output | 4 | Tag issued to the secondary lane |
| occ_p | output | 5 | Primary lane stage occupancy |
| occ_s | output | 5 | Secondary lane stage occupancy |
| wb_tag_p | output | 4 | Tag in primary writeback |
| wb_tag_s | output | 4 | Tag in secondary writeback |

## Verification
The hardest situation to reach from the ports is a stall that lands while a refused pair is split: the older instruction is already in address generation and the younger one is still waiting in decode, with a full prefetch register behind it. Directed sequences set each refusal reason in turn, starting from an empty pipeline. Seeded random traffic then uses narrow register fields, so dependencies are frequent, and raises stall requests about one cycle in eight. This lands stalls across split pairs many times. A cycle-level reference model in the bench checks every output at every cycle.

// File: rtl/dip_pkg.sv
package dip_pkg;
   localparam int NLANE = 2;
   localparam int NSTG  = 5;
   typedef enum logic [2:0] {
      STG_PF  = 3'd0,
      STG_DEC = 3'd1,
      STG_AG  = 3'd2,
      STG_EX  = 3'd3,
      STG_WB  = 3'd4
   } stage_e;
   localparam int NPOST = NSTG - int'(STG_AG);
endpackage

// File: rtl/dip_rules.sv
module dip_rules #(
   parameter int REG_W        = 3,
   parameter int TAG_W        = 4,
   parameter int FP_PAIR_SAME = 1,
   localparam int DW          = TAG_W + 3*REG_W + 5
) (
   input  logic [DW-1:0] old_i,
   input  logic [DW-1:0] yng_i,
   output logic          pair_ok_o
);
   localparam int O_DST = TAG_W;
   localparam int O_S1  = TAG_W + REG_W;
   localparam int O_S2  = TAG_W + 2*REG_W;
   localparam int O_WR  = TAG_W + 3*REG_W;
   localparam int O_FP  = O_WR + 1;
   localparam int O_CX  = O_WR + 2;
   localparam int O_DI  = O_WR + 3;
   localparam int O_IM  = O_WR + 4;

   logic [REG_W-1:0] o_dst, y_dst, y_s1, y_s2;
   logic raw, waw, form_bad, kind_ok;

   assign o_dst = old_i[O_DST +: REG_W];
   assign y_dst = yng_i[O_DST +: REG_W];
   assign y_s1  = yng_i[O_S1 +: REG_W];
   assign y_s2  = yng_i[O_S2 +: REG_W];

   assign raw = old_i[O_WR] && ((o_dst == y_s1) || (o_dst == y_s2));
   assign waw = old_i[O_WR] && yng_i[O_WR] && (o_dst == y_dst);
   assign form_bad = old_i[O_CX] | yng_i[O_CX] | old_i[O_DI] | yng_i[O_DI]
                   | old_i[O_IM] | yng_i[O_IM];

   generate
      if (FP_PAIR_SAME != 0) begin : g_fp_same
         assign kind_ok = (old_i[O_FP] == yng_i[O_FP]);
      end else begin : g_fp_never
         assign kind_ok = !old_i[O_FP] && !yng_i[O_FP];
      end
   endgenerate

   assign pair_ok_o = !raw && !waw && !form_bad && kind_ok;
endmodule

// File: rtl/dip_lane.sv
module dip_lane #(
   parameter int TAG_W = 4,
   parameter int DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             ins_vld_i,
   input  logic [TAG_W-1:0] ins_tag_i,
   output logic [DEPTH-1:0] occ_o,
   output logic [TAG_W-1:0] last_tag_o
);
   logic [DEPTH-1:0] vld;
   logic [TAG_W-1:0] tag [DEPTH];

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_stg
         if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  vld[s] <= 1'b0;
                  tag[s] <= '0;
               end else if (adv_i) begin
                  vld[s] <= ins_vld_i;
                  tag[s] <= ins_tag_i;
               end
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  vld[s] <= 1'b0;
                  tag[s] <= '0;
               end else if (adv_i) begin
                  vld[s] <= vld[s-1];
                  tag[s] <= tag[s-1];
               end
            end
         end
      end
   endgenerate

   assign occ_o      = vld;
   assign last_tag_o = tag[DEPTH-1];
endmodule

// File: rtl/dual_issue_pair_ctl.sv
module dual_issue_pair_ctl
   import dip_pkg::*;
#(
   parameter int REG_W        = 3,
   parameter int TAG_W        = 4,
   parameter int FP_PAIR_SAME = 1,
   localparam int DW          = TAG_W + 3*REG_W + 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       in_vld,
   input  logic [DW-1:0]    in_a,
   input  logic [DW-1:0]    in_b,
   output logic             in_ready,
   input  logic [1:0]       stall_req,
   output logic [1:0]       lane_stall,
   output logic             issue_pair,
   output logic             issue_single,
   output logic [TAG_W-1:0] issue_tag_p,
   output logic [TAG_W-1:0] issue_tag_s,
   output logic [NSTG-1:0]  occ_p,
   output logic [NSTG-1:0]  occ_s,
   output logic [TAG_W-1:0] wb_tag_p,
   output logic [TAG_W-1:0] wb_tag_s
);
   generate
      if (REG_W < 1 || TAG_W < 1) begin : g_bad_width
         $error("dual_issue_pair_ctl: REG_W and TAG_W must be at least 1");
      end
      if (FP_PAIR_SAME != 0 && FP_PAIR_SAME != 1) begin : g_bad_opt
         $error("dual_issue_pair_ctl: FP_PAIR_SAME must be 0 or 1");
      end
   endgenerate

   logic            hold;
   logic [1:0]      pf_vld, dec_vld;
   logic [DW-1:0]   pf_slot  [NLANE];
   logic [DW-1:0]   dec_slot [NLANE];
   logic            pair_ok, do_pair, do_single, dec_free, dec_load;
   logic [NLANE-1:0] ln_ins;
   logic [TAG_W-1:0] ln_tag  [NLANE];
   logic [NPOST-1:0] ln_occ  [NLANE];
   logic [TAG_W-1:0] ln_last [NLANE];

   assign hold       = |stall_req;
   assign lane_stall = {NLANE{hold}};

   dip_rules #(.REG_W(REG_W), .TAG_W(TAG_W), .FP_PAIR_SAME(FP_PAIR_SAME)) u_rules (
      .old_i     (dec_slot[0]),
      .yng_i     (dec_slot[1]),
      .pair_ok_o (pair_ok)
   );

   always_comb begin
      do_pair   = !hold && dec_vld[0] && dec_vld[1] && pair_ok;
      do_single = !hold && dec_vld[0] && !do_pair;
      dec_free  = !dec_vld[0] || do_pair || (do_single && !dec_vld[1]);
      dec_load  = !hold && dec_free && pf_vld[0];
      in_ready  = !hold && (!pf_vld[0] || dec_load);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf_vld  <= '0;
         dec_vld <= '0;
         for (int i = 0; i < NLANE; i++) begin
            pf_slot[i]  <= '0;
            dec_slot[i] <= '0;
         end
      end else if (!hold) begin
         if (dec_load) begin
            dec_vld     <= pf_vld;
            dec_slot[0] <= pf_slot[0];
            dec_slot[1] <= pf_slot[1];
         end else if (do_pair) begin
            dec_vld <= 2'b00;
         end else if (do_single) begin
            dec_vld     <= {1'b0, dec_vld[1]};
            dec_slot[0] <= dec_slot[1];
         end
         if (in_ready) begin
            if (in_vld == 2'b10) begin
               pf_vld     <= 2'b01;
               pf_slot[0] <= in_b;
            end else begin
               pf_vld     <= in_vld;
               pf_slot[0] <= in_a;
               pf_slot[1] <= in_b;
            end
         end
      end
   end

   assign ln_ins[0] = do_pair | do_single;
   assign ln_ins[1] = do_pair;
   assign ln_tag[0] = dec_slot[0][TAG_W-1:0];
   assign ln_tag[1] = dec_slot[1][TAG_W-1:0];

   generate
      for (genvar l = 0; l < NLANE; l++) begin : g_lane
         dip_lane #(.TAG_W(TAG_W), .DEPTH(NPOST)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv_i      (!hold),
            .ins_vld_i  (ln_ins[l]),
            .ins_tag_i  (ln_tag[l]),
            .occ_o      (ln_occ[l]),
            .last_tag_o (ln_last[l])
         );
      end
   endgenerate

   assign issue_pair   = do_pair;
   assign issue_single = do_single;
   assign issue_tag_p  = ln_tag[0];
   assign issue_tag_s  = ln_tag[1];
   assign occ_p        = {ln_occ[0], dec_vld[0], pf_vld[0]};
   assign occ_s        = {ln_occ[1], dec_vld[1], pf_vld[1]};
   assign wb_tag_p     = ln_last[0];
   assign wb_tag_s     = ln_last[1];
endmodule

// File: rtl/dip_chk.sv
module dip_chk #(
   parameter int REG_W = 3,
   parameter int TAG_W = 4,
   localparam int DW   = TAG_W + 3*REG_W + 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    stall_req,
   input logic [1:0]    lane_stall,
   input logic          in_ready,
   input logic          issue_pair,
   input logic          issue_single,
   input logic [4:0]    occ_p,
   input logic [4:0]    occ_s,
   input logic [DW-1:0] dec_a,
   input logic [DW-1:0] dec_b,
   input logic [1:0]    dec_v
);
   localparam int O_DST = TAG_W;
   localparam int O_S1  = TAG_W + REG_W;
   localparam int O_S2  = TAG_W + 2*REG_W;
   localparam int O_WR  = TAG_W + 3*REG_W;

   assert_lockstep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lane_stall[0] == lane_stall[1]);
   assert_stall_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|stall_req) |-> (!issue_pair && !issue_single && !in_ready && lane_stall == 2'b11));
   assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|stall_req) |=> ($stable(occ_p) && $stable(occ_s)));
   assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_pair && issue_single));
   assert_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_pair |-> !(dec_a[O_WR] && (dec_a[O_DST +: REG_W] == dec_b[O_S1 +: REG_W]
                                    || dec_a[O_DST +: REG_W] == dec_b[O_S2 +: REG_W])));
   assert_waw_R4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_pair |-> !(dec_a[O_WR] && dec_b[O_WR] && dec_a[O_DST +: REG_W] == dec_b[O_DST +: REG_W]));
   assert_simple_R5: assert property (@(posedge clk) disable iff (!rst_n)
      issue_pair |-> !(dec_a[O_WR+3] || dec_a[O_WR+4] || dec_b[O_WR+3] || dec_b[O_WR+4]));
   assert_cplx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      issue_pair |-> !(dec_a[O_WR+2] || dec_b[O_WR+2]));
   assert_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_pair |-> (dec_a[O_WR+1] == dec_b[O_WR+1]));
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_single && dec_v[1]) |=> occ_p[1]);
   assert_adv_ag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|stall_req) && occ_p[2]) |=> occ_p[3]);
   assert_adv_ex_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|stall_req) && occ_s[3]) |=> occ_s[4]);
   assert_pair_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
      issue_pair |=> (occ_p[2] && occ_s[2]));
endmodule

bind dual_issue_pair_ctl dip_chk #(.REG_W(REG_W), .TAG_W(TAG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stall_req    (stall_req),
   .lane_stall   (lane_stall),
   .in_ready     (in_ready),
   .issue_pair   (issue_pair),
   .issue_single (issue_single),
   .occ_p        (occ_p),
   .occ_s        (occ_s),
   .dec_a        (dec_slot[0]),
   .dec_b        (dec_slot[1]),
   .dec_v        (dec_vld)
);

// File: tb/sim_dual_issue_pair_ctl.sv
`timescale 1ns/1ps
module sim_dual_issue_pair_ctl;
   localparam int REG_W = 3;
   localparam int TAG_W = 4;
   localparam int DW    = TAG_W + 3*REG_W + 5;
   localparam int O_DST = TAG_W;
   localparam int O_S1  = TAG_W + REG_W;
   localparam int O_S2  = TAG_W + 2*REG_W;
   localparam int O_WR  = TAG_W + 3*REG_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] in_vld = '0;
   logic [DW-1:0] in_a = '0, in_b = '0;
   logic [1:0] stall_req = '0;
   logic in_ready, issue_pair, issue_single;
   logic [1:0] lane_stall;
   logic [TAG_W-1:0] issue_tag_p, issue_tag_s, wb_tag_p, wb_tag_s;
   logic [4:0] occ_p, occ_s;

   always #5 clk = ~clk;

   dual_issue_pair_ctl u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
      .in_ready(in_ready), .stall_req(stall_req), .lane_stall(lane_stall),
      .issue_pair(issue_pair), .issue_single(issue_single),
      .issue_tag_p(issue_tag_p), .issue_tag_s(issue_tag_s),
      .occ_p(occ_p), .occ_s(occ_s), .wb_tag_p(wb_tag_p), .wb_tag_s(wb_tag_s)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // reference model state
   logic [1:0] m_pf_v = '0, m_dec_v = '0;
   logic [DW-1:0] m_pf [2];
   logic [DW-1:0] m_dec [2];
   logic [2:0] m_lv [2];
   logic [TAG_W-1:0] m_lt [2][3];
   logic e_pair, e_single, e_load, e_rdy, e_hold;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mk(input int tag, input int dst, input int s1, input int s2,
                                        input bit wr, input bit fp, input bit cx,
                                        input bit di, input bit im);
      logic [DW-1:0] d;
      d = '0;
      d[TAG_W-1:0]       = tag[TAG_W-1:0];
      d[O_DST +: REG_W]  = dst[REG_W-1:0];
      d[O_S1 +: REG_W]   = s1[REG_W-1:0];
      d[O_S2 +: REG_W]   = s2[REG_W-1:0];
      d[O_WR]   = wr;
      d[O_WR+1] = fp;
      d[O_WR+2] = cx;
      d[O_WR+3] = di;
      d[O_WR+4] = im;
      return d;
   endfunction

   // first pairing rule broken, "R2" when none
   function automatic string why(input logic [DW-1:0] a, input logic [DW-1:0] b);
      if (a[O_WR] && (a[O_DST +: REG_W] == b[O_S1 +: REG_W] || a[O_DST +: REG_W] == b[O_S2 +: REG_W]))
         return "R3";
      if (a[O_WR] && b[O_WR] && a[O_DST +: REG_W] == b[O_DST +: REG_W]) return "R4";
      if (a[O_WR+3] || a[O_WR+4] || b[O_WR+3] || b[O_WR+4]) return "R5";
      if (a[O_WR+2] || b[O_WR+2]) return "R6";
      if (a[O_WR+1] != b[O_WR+1]) return "R7";
      return "R2";
   endfunction

   task automatic model_reset();
      m_pf_v = '0; m_dec_v = '0;
      for (int l = 0; l < 2; l++) begin
         m_pf[l] = '0; m_dec[l] = '0; m_lv[l] = '0;
         for (int s = 0; s < 3; s++) m_lt[l][s] = '0;
      end
   endtask

   task automatic model_comb();
      e_hold   = |stall_req;
      e_pair   = !e_hold && m_dec_v == 2'b11 && why(m_dec[0], m_dec[1]) == "R2";
      e_single = !e_hold && m_dec_v[0] && !e_pair;
      e_load   = !e_hold && m_pf_v[0] &&
                 (!m_dec_v[0] || e_pair || (e_single && !m_dec_v[1]));
      e_rdy    = !e_hold && (!m_pf_v[0] || e_load);
   endtask

   task automatic model_step();
      if (e_hold) return;
      for (int l = 0; l < 2; l++) begin
         m_lv[l][2] = m_lv[l][1]; m_lt[l][2] = m_lt[l][1];
         m_lv[l][1] = m_lv[l][0]; m_lt[l][1] = m_lt[l][0];
      end
      m_lv[0][0] = e_pair | e_single; m_lt[0][0] = m_dec[0][TAG_W-1:0];
      m_lv[1][0] = e_pair;            m_lt[1][0] = m_dec[1][TAG_W-1:0];
      if (e_load) begin
         m_dec_v = m_pf_v; m_dec[0] = m_pf[0]; m_dec[1] = m_pf[1];
      end else if (e_pair) begin
         m_dec_v = 2'b00;
      end else if (e_single) begin
         m_dec_v = {1'b0, m_dec_v[1]}; m_dec[0] = m_dec[1];
      end
      if (e_rdy) begin
         if (in_vld == 2'b10) begin
            m_pf_v = 2'b01; m_pf[0] = in_b;
         end else begin
            m_pf_v = in_vld; m_pf[0] = in_a; m_pf[1] = in_b;
         end
      end
   endtask

   task automatic cyc(input logic [1:0] v, input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic [1:0] st);
      string rq;
      @(negedge clk);
      in_vld = v; in_a = a; in_b = b; stall_req = st;
      #1;
      model_comb();
      chk(lane_stall == {2{e_hold}}, "R10", "lane_stall", 32'(lane_stall), 32'({2{e_hold}}));
      chk(in_ready == e_rdy, e_hold ? "R10" : "R8", "in_ready", 32'(in_ready), 32'(e_rdy));
      rq = (m_dec_v == 2'b11 && !e_hold) ? why(m_dec[0], m_dec[1]) : "R2";
      chk(issue_pair == e_pair, rq, "issue_pair", 32'(issue_pair), 32'(e_pair));
      chk(issue_single == e_single, (rq == "R2") ? "R8" : rq, "issue_single",
          32'(issue_single), 32'(e_single));
      if (e_pair || e_single)
         chk(issue_tag_p == m_dec[0][TAG_W-1:0], "R8", "issue_tag_p",
             32'(issue_tag_p), 32'(m_dec[0][TAG_W-1:0]));
      if (e_pair)
         chk(issue_tag_s == m_dec[1][TAG_W-1:0], "R2", "issue_tag_s",
             32'(issue_tag_s), 32'(m_dec[1][TAG_W-1:0]));
      chk(occ_p[0] == m_pf_v[0] && occ_s[0] == m_pf_v[1], "R11", "prefetch occupancy",
          32'({occ_s[0], occ_p[0]}), 32'({m_pf_v[1], m_pf_v[0]}));
      chk(occ_p == {m_lv[0], m_dec_v[0], m_pf_v[0]}, "R9", "occ_p",
          32'(occ_p), 32'({m_lv[0], m_dec_v[0], m_pf_v[0]}));
      chk(occ_s == {m_lv[1], m_dec_v[1], m_pf_v[1]}, "R9", "occ_s",
          32'(occ_s), 32'({m_lv[1], m_dec_v[1], m_pf_v[1]}));
      if (m_lv[0][2]) chk(wb_tag_p == m_lt[0][2], "R9", "wb_tag_p", 32'(wb_tag_p), 32'(m_lt[0][2]));
      if (m_lv[1][2]) chk(wb_tag_s == m_lt[1][2], "R9", "wb_tag_s", 32'(wb_tag_s), 32'(m_lt[1][2]));
      @(posedge clk);
      model_step();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(2'b00, '0, '0, 2'b00);
   endtask

   task automatic finish_up();
      if (finished) return;
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(10 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(occ_p == 5'b0 && occ_s == 5'b0, "R1", "occupancy", 32'({occ_s, occ_p}), 32'h0);
      chk(!issue_pair && !issue_single, "R1", "issue", 32'({issue_pair, issue_single}), 32'h0);
      chk(lane_stall == 2'b00, "R1", "lane_stall", 32'(lane_stall), 32'h0);
      chk(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 32'h1);
      rst_n = 1'b1;
      idle(1);
      // R2 independent pair
      cyc(2'b11, mk(1, 1, 2, 3, 1, 0, 0, 0, 0), mk(2, 4, 5, 6, 1, 0, 0, 0, 0), 2'b00); idle(6);
      // R3 read after write
      cyc(2'b11, mk(3, 2, 0, 0, 1, 0, 0, 0, 0), mk(4, 5, 1, 2, 1, 0, 0, 0, 0), 2'b00); idle(6);
      // R4 same destination
      cyc(2'b11, mk(5, 6, 0, 1, 1, 0, 0, 0, 0), mk(6, 6, 2, 3, 1, 0, 0, 0, 0), 2'b00); idle(6);
      // R5 displacement then immediate
      cyc(2'b11, mk(7, 1, 2, 3, 1, 0, 0, 1, 0), mk(8, 4, 5, 6, 1, 0, 0, 0, 0), 2'b00); idle(6);
      cyc(2'b11, mk(9, 1, 2, 3, 1, 0, 0, 0, 0), mk(10, 4, 5, 6, 1, 0, 0, 0, 1), 2'b00); idle(6);
      // R6 complex younger
      cyc(2'b11, mk(11, 1, 2, 3, 1, 0, 0, 0, 0), mk(12, 4, 5, 6, 1, 0, 1, 0, 0), 2'b00); idle(6);
      // R7 fp with int, then fp with fp
      cyc(2'b11, mk(13, 1, 2, 3, 1, 1, 0, 0, 0), mk(14, 4, 5, 6, 1, 0, 0, 0, 0), 2'b00); idle(6);
      cyc(2'b11, mk(15, 1, 2, 3, 1, 1, 0, 0, 0), mk(0, 4, 5, 6, 1, 1, 0, 0, 0), 2'b00); idle(6);
      // R11 only younger slot valid
      cyc(2'b10, mk(1, 1, 1, 1, 1, 0, 0, 0, 0), mk(9, 7, 2, 3, 1, 0, 0, 0, 0), 2'b00); idle(6);
      // R10 stall across a split pair with traffic behind it
      cyc(2'b11, mk(2, 3, 0, 0, 1, 0, 0, 0, 0), mk(3, 4, 3, 0, 1, 0, 0, 0, 0), 2'b00);
      cyc(2'b11, mk(4, 1, 2, 2, 1, 0, 0, 0, 0), mk(5, 6, 7, 7, 1, 0, 0, 0, 0), 2'b00);
      cyc(2'b00, '0, '0, 2'b00);
      cyc(2'b11, mk(6, 0, 1, 1, 0, 0, 0, 0, 0), mk(7, 2, 2, 2, 0, 0, 0, 0, 0), 2'b01);
      cyc(2'b00, '0, '0, 2'b10);
      cyc(2'b00, '0, '0, 2'b11);
      idle(8);
      // seeded random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] v, st;
         logic [DW-1:0] a, b;
         v  = 2'($urandom_range(0, 3));
         st = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
         a  = mk(int'($urandom_range(0, 15)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 7)), $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
         b  = mk(int'($urandom_range(0, 15)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 7)), $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
         cyc(v, a, b, st);
      end
      idle(8);
      finish_up();
   end
endmodule